// File: doc/BRIEF.md
# Content-protection control register unit

This block is one 8-bit control register at address 0xC3 that commands the content-protection engine of a serial link transmitter. Software reaches it through a plain register port: an address, write data, a write strobe and a combinational read-data bus. Most bits act as commands rather than storage. Writing a 1 to such a bit issues a single-cycle pulse to the authentication engine and the bit reads back as 0. The commands are engine reset, start or restart, stop, "receiver key checked" and "repeater key list checked".

The register also keeps three pieces of state. The first is whether authentication is enabled. The second is a receiver-key confirmation that stays set until the engine raises its key-ready flag. The third is an encryption-enable flag. The encryption-enable flag, the engine's authenticated flag and an always-encrypt configuration input together choose what the video path sends: plain video, encrypted video, or a fixed blue screen.

Top module: `cp_ctrl_top`

## Requirements
- R1: After reset, every command pulse is 0, `encryptOn` is 0, `videoSel` is 2'b00, and a read of 0xC3 returns 0x00 while `alwaysEncrypt` is 0.
- R2: A write to 0xC3 with bit 7 set does three things. It pulses `cmdReset` high for exactly the cycle after the write. It raises no other command pulse. It clears the enabled state, the held key confirmation and the encryption flag, whatever the other bits of that write are.
- R3: A write with bit 0 set and bits 1 and 7 clear pulses `cmdStart` in the next cycle and sets the enabled state, which reads back on bit 0. A repeated write of bit 0 pulses again. Writing 0 to bit 0 leaves the enabled state unchanged.
- R4: A write with bit 1 set, and bit 7 clear, pulses `cmdDisable` and clears the enabled state. If bit 0 is also set in that write, `cmdStart` stays 0.
- R5: A write with bit 5 set, and bit 7 clear, pulses `cmdListValid` in the next cycle. Bit 5 always reads 0.
- R6: A write with bit 4 set, and bit 7 clear, pulses `cmdKeyValid` and sets a held confirmation that reads on bit 4. The confirmation clears after any cycle in which `keyReady` is 1 and no such write occurs. Writing 0 to bit 4 has no effect.
- R7: A write with bit 2 set enables encryption. A write with bit 3 set disables it and wins when both bits are set. Bit 3 reads 0, and bit 2 reads the effective encryption state, which is also the `encryptOn` output.
- R8: `videoSel` encodes the outgoing source as 2'b00 plain, 2'b01 encrypted and 2'b10 blue screen. It is plain when encryption is off, encrypted when encryption is on and `authDone` is 1, and blue when encryption is on and `authDone` is 0. It never takes the value 2'b11.
- R9: While `alwaysEncrypt` is 1, `encryptOn` is 1 and bit 2 reads 1, whatever has been written to bits 2 and 3.
- R10: Bits 7, 6, 5, 3 and 1 always read 0. Writes to any address other than 0xC3 change no state and raise no pulse. A read of any other address returns 0x00.
- R11: Each cycle in which a qualifying write is strobed produces exactly one single-cycle pulse per command bit. Two back-to-back write cycles give two pulses, and no pulse outlasts its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register address for read and write |
| regWrData | input | 8 | Write data |
| regWrEn | input | 1 | Write strobe, one write per cycle it is high |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| keyReady | input | 1 | Engine flag: receiver key ready, clears held key confirmation |
| authDone | input | 1 | Engine flag: link authenticated |
| alwaysEncrypt | input | 1 | Configuration forcing encryption on |
| cmdReset | output | 1 | Engine reset pulse |
| cmdStart | output | 1 | Authentication start/restart pulse |
| cmdDisable | output | 1 | Authentication stop pulse |
| cmdListValid | output | 1 | Repeater key list checked pulse |
| cmdKeyValid | output | 1 | Receiver key checked pulse |
| encryptOn | output | 1 | Effective encryption enable |
| videoSel | output | 2 | Video source: 00 plain, 01 encrypted, 10 blue screen |

## Verification
A write sampled at a rising edge produces its command pulses and its state change in the cycle that follows that edge. Read data, `encryptOn` and `videoSel` are combinational from the stored state and the current inputs, so they follow `authDone`, `alwaysEncrypt` and `regAddr` in the same cycle. The bench drives every input on the falling edge and compares all outputs with a behavioural model one falling edge after the rising edge that acts on them. The directed checks that name requirements are sampled at that same point, one falling edge after each write.

// File: rtl/cp_ctrl_pkg.sv
package cp_ctrl_pkg;

  // Bit positions inside the control word; the engine-side decode depends on them.
  localparam int BIT_START  = 0;
  localparam int BIT_STOP   = 1;
  localparam int BIT_ENCON  = 2;
  localparam int BIT_ENCOFF = 3;
  localparam int BIT_KEYOK  = 4;
  localparam int BIT_LISTOK = 5;
  localparam int BIT_RSVD   = 6;
  localparam int BIT_RESET  = 7;

  // Order of the command pulse vector.
  localparam int PULSE_N      = 5;
  localparam int P_RESET      = 4;
  localparam int P_START      = 3;
  localparam int P_STOP       = 2;
  localparam int P_LISTOK     = 1;
  localparam int P_KEYOK      = 0;

  typedef struct packed {
    logic doReset;
    logic doStart;
    logic doStop;
    logic doListOk;
    logic doKeyOk;
    logic doEncOn;
    logic doEncOff;
  } cmdStrobes_t;

  typedef enum logic [1:0] {
    VID_PLAIN  = 2'b00,
    VID_CIPHER = 2'b01,
    VID_BLUE   = 2'b10
  } vidSel_e;

endpackage

// File: rtl/cp_ctrl_decode.sv
module cp_ctrl_decode
  import cp_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hC3
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  output cmdStrobes_t       strobes
);

  logic hit;
  logic rstReq;

  assign hit    = regWrEn && (regAddr == REG_ADDR);
  assign rstReq = hit && regWrData[BIT_RESET];

  // Reset write masks every other bit; stop beats start; encrypt-off beats encrypt-on.
  always_comb begin
    strobes          = '0;
    strobes.doReset  = rstReq;
    if (hit && !rstReq) begin
      strobes.doStop   = regWrData[BIT_STOP];
      strobes.doStart  = regWrData[BIT_START] && !regWrData[BIT_STOP];
      strobes.doListOk = regWrData[BIT_LISTOK];
      strobes.doKeyOk  = regWrData[BIT_KEYOK];
      strobes.doEncOff = regWrData[BIT_ENCOFF];
      strobes.doEncOn  = regWrData[BIT_ENCON] && !regWrData[BIT_ENCOFF];
    end
  end

endmodule

// File: rtl/cp_ctrl_state.sv
module cp_ctrl_state
  import cp_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobes_t       strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              keyReady,
  input  logic              authDone,
  input  logic              alwaysEncrypt,
  output logic [PULSE_N-1:0] pulses,
  output logic              encryptOn,
  output logic [1:0]        videoSel,
  output logic [DATA_W-1:0] regRdData
);

  logic [PULSE_N-1:0] pulseNext;
  logic authEnabled;
  logic keyHeld;
  logic encStored;
  vidSel_e vidNow;

  assign pulseNext[P_RESET]  = strobes.doReset;
  assign pulseNext[P_START]  = strobes.doStart;
  assign pulseNext[P_STOP]   = strobes.doStop;
  assign pulseNext[P_LISTOK] = strobes.doListOk;
  assign pulseNext[P_KEYOK]  = strobes.doKeyOk;

  // One flop per command pulse.
  for (genvar i = 0; i < PULSE_N; i++) begin : g_pulse
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pulses[i] <= 1'b0;
      else       pulses[i] <= pulseNext[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      authEnabled <= 1'b0;
      keyHeld     <= 1'b0;
      encStored   <= 1'b0;
    end else if (strobes.doReset) begin
      authEnabled <= 1'b0;
      keyHeld     <= 1'b0;
      encStored   <= 1'b0;
    end else begin
      if (strobes.doStop)        authEnabled <= 1'b0;
      else if (strobes.doStart)  authEnabled <= 1'b1;
      if (strobes.doKeyOk)       keyHeld <= 1'b1;
      else if (keyReady)         keyHeld <= 1'b0;
      if (strobes.doEncOff)      encStored <= 1'b0;
      else if (strobes.doEncOn)  encStored <= 1'b1;
    end
  end

  assign encryptOn = encStored || alwaysEncrypt;

  always_comb begin
    if (!encryptOn)    vidNow = VID_PLAIN;
    else if (authDone) vidNow = VID_CIPHER;
    else               vidNow = VID_BLUE;
  end
  assign videoSel = vidNow;

  always_comb begin
    regRdData = '0;
    if (regAddr == REG_ADDR) begin
      regRdData[BIT_START] = authEnabled;
      regRdData[BIT_ENCON] = encryptOn;
      regRdData[BIT_KEYOK] = keyHeld;
    end
  end

  // R6: key-ready with no new confirmation leaves the held bit clear.
  assert_key_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (keyReady && !strobes.doKeyOk) |=> !keyHeld);

  // R8: encoding of the video source.
  assert_vid_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    (videoSel != 2'b11) && (!encryptOn -> videoSel == VID_PLAIN));

  assert_vid_cipher_R8: assert property (@(posedge clk) disable iff (!rstN)
    (encryptOn && authDone) |-> (videoSel == VID_CIPHER));

  // R9: forced encryption.
  assert_force_enc_R9: assert property (@(posedge clk) disable iff (!rstN)
    alwaysEncrypt |-> encryptOn);

  // R2: a reset write clears state one cycle later.
  assert_reset_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doReset |=> (!authEnabled && !keyHeld && !encStored));

endmodule

// File: rtl/cp_ctrl_top.sv
module cp_ctrl_top
  import cp_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  output logic [DATA_W-1:0] regRdData,
  input  logic              keyReady,
  input  logic              authDone,
  input  logic              alwaysEncrypt,
  output logic              cmdReset,
  output logic              cmdStart,
  output logic              cmdDisable,
  output logic              cmdListValid,
  output logic              cmdKeyValid,
  output logic              encryptOn,
  output logic [1:0]        videoSel
);

  cmdStrobes_t strobes;
  logic [PULSE_N-1:0] pulses;

  cp_ctrl_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_decode (
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regWrEn  (regWrEn),
    .strobes  (strobes)
  );

  cp_ctrl_state #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_state (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .regAddr      (regAddr),
    .keyReady     (keyReady),
    .authDone     (authDone),
    .alwaysEncrypt(alwaysEncrypt),
    .pulses       (pulses),
    .encryptOn    (encryptOn),
    .videoSel     (videoSel),
    .regRdData    (regRdData)
  );

  assign cmdReset     = pulses[P_RESET];
  assign cmdStart     = pulses[P_START];
  assign cmdDisable   = pulses[P_STOP];
  assign cmdListValid = pulses[P_LISTOK];
  assign cmdKeyValid  = pulses[P_KEYOK];

  logic wrHit;
  assign wrHit = regWrEn && (regAddr == REG_ADDR);

  // R2: a reset pulse never travels with another command.
  assert_reset_alone_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdReset |-> !(cmdStart || cmdDisable || cmdListValid || cmdKeyValid));

  // R4: stop and start in one write yields only the stop pulse.
  assert_stop_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && regWrData[BIT_START] && regWrData[BIT_STOP] && !regWrData[BIT_RESET])
      |=> (cmdDisable && !cmdStart));

  // R11: without a write in the previous cycle no pulse is present.
  assert_no_stray_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit |=> !(cmdReset || cmdStart || cmdDisable || cmdListValid || cmdKeyValid));

  // R10: command and reserved bits read 0; other addresses read 0.
  assert_read_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[7] == 1'b0) && (regRdData[6] == 1'b0) && (regRdData[5] == 1'b0) &&
    (regRdData[3] == 1'b0) && (regRdData[1] == 1'b0));

  assert_other_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != REG_ADDR) |-> (regRdData == '0));

endmodule

// File: tb/cp_ctrl_top_tb.sv
module cp_ctrl_top_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regAddr = 8'hC3;
  logic [7:0] regWrData = 8'h00;
  logic regWrEn = 1'b0;
  logic keyReady = 1'b0;
  logic authDone = 1'b0;
  logic alwaysEncrypt = 1'b0;
  logic [7:0] regRdData;
  logic cmdReset, cmdStart, cmdDisable, cmdListValid, cmdKeyValid, encryptOn;
  logic [1:0] videoSel;

  integer checks = 0;
  integer errors = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cp_ctrl_top u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .keyReady(keyReady),
    .authDone(authDone), .alwaysEncrypt(alwaysEncrypt), .cmdReset(cmdReset),
    .cmdStart(cmdStart), .cmdDisable(cmdDisable), .cmdListValid(cmdListValid),
    .cmdKeyValid(cmdKeyValid), .encryptOn(encryptOn), .videoSel(videoSel)
  );

  // Behavioural reference state.
  integer mEn = 0, mKey = 0, mEnc = 0;
  integer mRst = 0, mStart = 0, mStop = 0, mList = 0, mKeyP = 0;

  always @(posedge clk) begin
    integer hit;
    mRst = 0; mStart = 0; mStop = 0; mList = 0; mKeyP = 0;
    if (!rstN) begin
      mEn = 0; mKey = 0; mEnc = 0;
    end else begin
      hit = (regWrEn && regAddr == 8'hC3) ? 1 : 0;
      if (hit != 0 && regWrData[7]) begin
        mRst = 1; mEn = 0; mKey = 0; mEnc = 0;
      end else begin
        if (hit != 0 && regWrData[1]) begin mStop = 1; mEn = 0; end
        else if (hit != 0 && regWrData[0]) begin mStart = 1; mEn = 1; end
        if (hit != 0 && regWrData[5]) mList = 1;
        if (hit != 0 && regWrData[4]) begin mKeyP = 1; mKey = 1; end
        else if (keyReady) mKey = 0;
        if (hit != 0 && regWrData[3]) mEnc = 0;
        else if (hit != 0 && regWrData[2]) mEnc = 1;
      end
    end
  end

  task automatic check(input string tag, input integer act, input integer exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    integer effEnc, vid, rd;
    if (cmpOn) begin
      effEnc = (mEnc != 0 || alwaysEncrypt) ? 1 : 0;
      vid = (effEnc == 0) ? 0 : (authDone ? 1 : 2);
      rd = (regAddr == 8'hC3) ? (mKey * 16 + effEnc * 4 + mEn) : 0;
      check("R2 model cmdReset", cmdReset, mRst);
      check("R3 model cmdStart", cmdStart, mStart);
      check("R4 model cmdDisable", cmdDisable, mStop);
      check("R5 model cmdListValid", cmdListValid, mList);
      check("R6 model cmdKeyValid", cmdKeyValid, mKeyP);
      check("R7 model encryptOn", encryptOn, effEnc);
      check("R8 model videoSel", videoSel, vid);
      check("R10 model regRdData", regRdData, rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 8'hC3;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        #1;
        cmpOn = 1'b1;
        // R1 reset state
        check("R1 read after reset", regRdData, 8'h00);
        check("R1 videoSel after reset", videoSel, 0);
        check("R1 pulses after reset", {cmdReset, cmdStart, cmdDisable, cmdListValid, cmdKeyValid}, 0);
        // R3 start, hold, restart
        wr(8'hC3, 8'h01);
        check("R3 start pulse", cmdStart, 1);
        check("R3 enabled reads 1", regRdData[0], 1);
        idle();
        check("R11 pulse lasts one cycle", cmdStart, 0);
        wr(8'hC3, 8'h00);
        check("R3 write 0 keeps enabled", regRdData[0], 1);
        wr(8'hC3, 8'h01);
        check("R3 restart pulse", cmdStart, 1);
        // R4 stop beats start
        wr(8'hC3, 8'h03);
        check("R4 disable pulse", cmdDisable, 1);
        check("R4 no start pulse", cmdStart, 0);
        check("R4 enabled cleared", regRdData[0], 0);
        // R5 list confirmation
        wr(8'hC3, 8'h20);
        check("R5 list pulse", cmdListValid, 1);
        check("R5 bit reads 0", regRdData[5], 0);
        // R6 held key confirmation
        wr(8'hC3, 8'h10);
        check("R6 key pulse", cmdKeyValid, 1);
        check("R6 held reads 1", regRdData[4], 1);
        wr(8'hC3, 8'h00);
        check("R6 write 0 no effect", regRdData[4], 1);
        @(negedge clk); keyReady = 1'b1;
        @(negedge clk); keyReady = 1'b0; #1;
        check("R6 cleared by keyReady", regRdData[4], 0);
        // R7/R8 encryption and video source
        wr(8'hC3, 8'h04);
        check("R7 encrypt on", encryptOn, 1);
        check("R8 blue when unauthenticated", videoSel, 2);
        @(negedge clk); authDone = 1'b1; #1;
        check("R8 cipher when authenticated", videoSel, 1);
        wr(8'hC3, 8'h08);
        check("R7 encrypt off", encryptOn, 0);
        check("R8 plain when off", videoSel, 0);
        wr(8'hC3, 8'h0C);
        check("R7 off wins over on", encryptOn, 0);
        // R9 forced encryption
        @(negedge clk); alwaysEncrypt = 1'b1; #1;
        check("R9 forced encryptOn", encryptOn, 1);
        check("R9 bit 2 reads 1", regRdData[2], 1);
        wr(8'hC3, 8'h08);
        check("R9 disable has no effect", encryptOn, 1);
        @(negedge clk); alwaysEncrypt = 1'b0; authDone = 1'b0;
        // R2 reset overrides other bits
        wr(8'hC3, 8'h01);
        wr(8'hC3, 8'h14);
        wr(8'hC3, 8'hB7);
        check("R2 reset pulse", cmdReset, 1);
        check("R2 other pulses masked", {cmdStart, cmdDisable, cmdListValid, cmdKeyValid}, 0);
        check("R2 state cleared", regRdData, 8'h00);
        // R10 other address and reserved bit
        wr(8'hC3, 8'h05);
        wr(8'h10, 8'hFF);
        check("R10 no pulse for other address", {cmdReset, cmdStart, cmdDisable, cmdListValid, cmdKeyValid}, 0);
        check("R10 state unchanged", regRdData, 8'h05);
        @(negedge clk); regAddr = 8'h10; #1;
        check("R10 other address reads 0", regRdData, 8'h00);
        wr(8'hC3, 8'h40);
        check("R10 reserved bit reads 0", regRdData[6], 0);
        // R11 back-to-back writes
        @(negedge clk);
        regAddr = 8'hC3; regWrData = 8'h01; regWrEn = 1'b1;
        @(negedge clk); #1;
        check("R11 first back-to-back pulse", cmdStart, 1);
        @(negedge clk); regWrEn = 1'b0; #1;
        check("R11 second back-to-back pulse", cmdStart, 1);
        idle();
        check("R11 pulse ends", cmdStart, 0);
        repeat (3) idle();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks = checks + 1;
          errors = errors + 1;
          $display("FAIL watchdog expired actual=hung expected=finished");
        end
      end
    join_any
    cmpOn = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule